// File: doc/BRIEF.md
# Strobe-clocked serial register slave

This block is the device end of a four-pin bit-serial register link. A host drives three pins (a frame clear, a strobe and a data line toward the device) and reads one data line back. All pins are asynchronous to the block's clock. The block passes each pin through a two-flop synchroniser and finds strobe edges in the synchronised copy.

A transaction starts when the clear line returns high after a low pulse. The host then sends an address byte and a 16-bit data phase. A write captures sixteen bits into a small register file. A read shifts a register value out on the return pin. The register file holds two identity words and three banks of read/write control words: function enables, GPIO enables and GPIO directions. The control words appear on output ports for the logic around the block. Each address has its own read and write permission.

The host must hold every pin level for at least four clock cycles. Edges that come faster than that may be lost in the synchroniser.

Top module: `strobe_reg_slave`

## Requirements
- R1: A low level on the clear pin aborts any partial transfer at any point. The next transaction starts from bit 0 of the address byte once clear is high again, and the aborted transfer changes no register.
- R2: After clear goes high, the first 8 strobe rising edges sample the data-in pin into an address byte, most significant bit first. Bit 7 of that byte is the direction flag (1 = read, 0 = write) and bits 6..0 are the register address.
- R3: On a write, the next 16 rising edges sample data-in most significant bit first. The target register keeps its old value after the 15th bit and takes the assembled word only after the 16th.
- R4: On a read, data-out carries bit 15 of the addressed register once the first data-phase strobe pulse has fallen. Each later pulse presents the next lower bit, so the host can sample after every falling edge.
- R5: The strobe rising edge that follows the 16th data bit, and any strobe edges after it, start no new transfer and change no register. Data-out returns low on that edge. Only the clear pin opens a new transaction.
- R6: Address 0x10 reads the platform identity word (parameter, low byte = manufacturer code 0x01). Writes to it are ignored.
- R7: Address 0x11 reads the firmware identity word (parameter; bits 15..12 build, 11..8 major = 0, 7..4 minor, 3..0 patch). Writes to it are ignored.
- R8: Addresses 0x20–0x21 (function enable), 0x30–0x32 (GPIO enable) and 0x40–0x42 (GPIO direction) are readable and writable. Register base+i is driven on bits [16i+15:16i] of func_en_o, gpio_en_o or gpio_dir_o respectively.
- R9: A read of any address other than those in R6–R8 returns 0x0000. A write to such an address changes no register.
- R10: All writable registers are 0x0000 after reset.
- R11: Data-out is low while the block is in reset, while clear is low, and during the whole address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Frame clear from host, active low, asynchronous |
| stb_i | input | 1 | Bit strobe from host, asynchronous |
| din_i | input | 1 | Serial data from host, asynchronous |
| dout_o | output | 1 | Serial read data to host |
| func_en_o | output | FUNC_N*16 | Function enable registers, flattened |
| gpio_en_o | output | GPIO_N*16 | GPIO enable registers, flattened |
| gpio_dir_o | output | GPIO_N*16 | GPIO direction registers, flattened |

## Verification
The bench builds the block with the default bank sizes (two function words, three GPIO words each) and a 7-bit address. The platform word is set to 0xC301 and the firmware word to 0x7035. A 7-bit address makes the whole address space small enough to sweep completely. Every one of the 128 addresses is read after reset, written with an address-derived pattern, and read again, with the expected word worked out arithmetically from the address class. Separate sequences abort frames mid-address and mid-data, probe the register between the 15th and 16th write bits, and send surplus strobe edges after a finished transfer.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  localparam int unsigned PLAT_ADDR     = 32'h10;
  localparam int unsigned FW_ADDR       = 32'h11;
  localparam int unsigned FUNC_BASE     = 32'h20;
  localparam int unsigned GPIO_EN_BASE  = 32'h30;
  localparam int unsigned GPIO_DIR_BASE = 32'h40;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srl_frame.sv
module srl_frame
  import srl_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic              din_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              dout_o
);
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned MAXB   = (BYTE_W > DATA_W) ? BYTE_W : DATA_W;
  localparam int unsigned CNT_W  = $clog2(MAXB + 1);

  phase_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W:0]   adr_q;
  logic              rd_q;
  logic [DATA_W-1:0] sh_q;
  logic              wr_q;
  logic              stb_q;
  logic              rise;
  logic [ADDR_W:0]   adr_nxt;

  assign rise      = stb_i & ~stb_q;
  assign adr_nxt   = {adr_q[ADDR_W-1:0], din_i};
  assign rd_addr_o = adr_nxt[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_ADDR;
      cnt_q <= '0;
      adr_q <= '0;
      rd_q  <= 1'b0;
      sh_q  <= '0;
      wr_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_i;
      wr_q  <= 1'b0;
      if (!clr_i) begin
        st_q  <= PH_ADDR;
        cnt_q <= '0;
        rd_q  <= 1'b0;
      end else if (rise) begin
        unique case (st_q)
          PH_ADDR: begin
            adr_q <= adr_nxt;
            if (cnt_q == CNT_W'(ADDR_W)) begin
              st_q  <= PH_DATA;
              cnt_q <= '0;
              rd_q  <= adr_nxt[ADDR_W];
              sh_q  <= adr_nxt[ADDR_W] ? rd_data_i : '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            // read: first pulse keeps bit 15 on the pin, later pulses shift
            if (rd_q) begin
              if (cnt_q != '0) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            end else begin
              sh_q <= {sh_q[DATA_W-2:0], din_i};
            end
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              st_q  <= PH_TAIL;
              cnt_q <= '0;
              wr_q  <= ~rd_q;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_TAIL: st_q <= PH_DONE;
          default: ;
        endcase
      end
    end
  end

  assign wr_o      = wr_q;
  assign wr_addr_o = adr_q[ADDR_W-1:0];
  assign wr_data_o = sh_q;
  assign dout_o    = rd_q && (st_q == PH_DATA || st_q == PH_TAIL) && sh_q[DATA_W-1];

  // R1
  clr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (st_q == PH_ADDR && cnt_q == '0 && !wr_q));
  // R3
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  // R3
  wr_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (st_q == PH_TAIL && $past(st_q) == PH_DATA && !rd_q));
  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_DONE && clr_i) |=> (st_q == PH_DONE && !wr_q));
endmodule

// File: rtl/srl_bank.sv
module srl_bank #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BASE   = 32'h20,
  parameter int unsigned N      = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [N*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      regs_q[i] <= '0;
      else if (wr_i && wr_addr_i == ADDR_W'(BASE + i)) regs_q[i] <= wr_data_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_addr_i == ADDR_W'(BASE + i)) rd_data_o = regs_q[i];
    end
  end

  // R9
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(regs_o));
endmodule

// File: rtl/srl_regfile.sv
module srl_regfile
  import srl_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 7,
  parameter int unsigned       DATA_W  = 16,
  parameter int unsigned       FUNC_N  = 2,
  parameter int unsigned       GPIO_N  = 3,
  parameter logic [DATA_W-1:0] PLAT_ID = 16'h0001,
  parameter logic [DATA_W-1:0] FW_ID   = 16'h1023
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic [FUNC_N*DATA_W-1:0] func_o,
  output logic [GPIO_N*DATA_W-1:0] gen_o,
  output logic [GPIO_N*DATA_W-1:0] gdir_o
);
  logic [DATA_W-1:0] func_rd, gen_rd, gdir_rd;

  srl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(FUNC_BASE), .N(FUNC_N)) u_func (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o(func_rd), .regs_o(func_o));

  srl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(GPIO_EN_BASE), .N(GPIO_N)) u_gen (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o(gen_rd), .regs_o(gen_o));

  srl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(GPIO_DIR_BASE), .N(GPIO_N)) u_gdir (
    .clk_i, .rst_ni, .wr_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o(gdir_rd), .regs_o(gdir_o));

  always_comb begin
    if (rd_addr_i == ADDR_W'(PLAT_ADDR))    rd_data_o = PLAT_ID;
    else if (rd_addr_i == ADDR_W'(FW_ADDR)) rd_data_o = FW_ID;
    else                                    rd_data_o = func_rd | gen_rd | gdir_rd;
  end

  // R6
  plat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i == ADDR_W'(PLAT_ADDR)) |=> $stable({func_o, gen_o, gdir_o}));
  // R7
  fw_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i == ADDR_W'(FW_ADDR)) |=> $stable({func_o, gen_o, gdir_o}));
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave #(
  parameter int unsigned  ADDR_W  = 7,
  parameter int unsigned  DATA_W  = 16,
  parameter int unsigned  FUNC_N  = 2,
  parameter int unsigned  GPIO_N  = 3,
  parameter int unsigned  SYNC_N  = 2,
  parameter logic [15:0]  PLAT_ID = 16'h0001,
  parameter logic [15:0]  FW_ID   = 16'h1023
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     stb_i,
  input  logic                     din_i,
  output logic                     dout_o,
  output logic [FUNC_N*DATA_W-1:0] func_en_o,
  output logic [GPIO_N*DATA_W-1:0] gpio_en_o,
  output logic [GPIO_N*DATA_W-1:0] gpio_dir_o
);
  logic [2:0]        pins_s;
  logic              clr_s, stb_s, din_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr;

  srl_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .d_i({clr_i, stb_i, din_i}), .q_o(pins_s));

  assign {clr_s, stb_s, din_s} = pins_s;

  srl_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i, .rst_ni,
    .clr_i(clr_s), .stb_i(stb_s), .din_i(din_s),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .dout_o);

  srl_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FUNC_N(FUNC_N), .GPIO_N(GPIO_N),
    .PLAT_ID(DATA_W'(PLAT_ID)), .FW_ID(DATA_W'(FW_ID))
  ) u_regs (
    .clk_i, .rst_ni,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_i(wr), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .func_o(func_en_o), .gen_o(gpio_en_o), .gdir_o(gpio_dir_o));

  // R11
  dout_clr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_s |=> !dout_o);
endmodule

// File: tb/tb_strobe_reg_slave.sv
module tb_strobe_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;
  localparam logic [15:0] PLAT = 16'hC301;
  localparam logic [15:0] FW   = 16'h7035;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, stb = 1'b0, din = 1'b0;
  logic dout;
  logic [31:0] func_en;
  logic [47:0] gpio_en, gpio_dir;

  strobe_reg_slave #(.PLAT_ID(PLAT), .FW_ID(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .stb_i(stb), .din_i(din),
    .dout_o(dout), .func_en_o(func_en), .gpio_en_o(gpio_en), .gpio_dir_o(gpio_dir));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] mdl [128];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit wrable(int a);
    return (a >= 32 && a <= 33) || (a >= 48 && a <= 50) || (a >= 64 && a <= 66);
  endfunction

  function automatic string cls(int a);
    if (a == 16) return "R6";
    if (a == 17) return "R7";
    if (wrable(a)) return "R8";
    return "R9";
  endfunction

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic chk_ports(string req);
    for (int i = 0; i < 2; i++) chk({req, " func_en"}, func_en[i*16 +: 16], mdl[32+i]);
    for (int i = 0; i < 3; i++) chk({req, " gpio_en"}, gpio_en[i*16 +: 16], mdl[48+i]);
    for (int i = 0; i < 3; i++) chk({req, " gpio_dir"}, gpio_dir[i*16 +: 16], mdl[64+i]);
  endtask

  task automatic frame_start();
    clr = 1'b0; hold();
    chk("R11 dout during clear", {15'b0, dout}, 16'h0);
    clr = 1'b1; hold();
  endtask

  task automatic send_addr(bit rd, logic [6:0] a);
    logic [7:0] b;
    b = {rd, a};
    for (int i = 7; i >= 0; i--) begin
      stb = 1'b0; din = b[i]; hold();
      chk("R11 dout in address phase", {15'b0, dout}, 16'h0);
      stb = 1'b1; hold();
    end
  endtask

  task automatic wr_reg(logic [6:0] a, logic [15:0] v, bit probe);
    frame_start();
    send_addr(1'b0, a);
    stb = 1'b0; hold();
    for (int i = 15; i >= 0; i--) begin
      din = v[i]; hold();
      stb = 1'b1; hold();
      stb = 1'b0; hold();
      if (probe && i == 1) chk_ports("R3 before 16th bit");
    end
    stb = 1'b1; hold();
    din = 1'b0;
    if (wrable(int'(a))) mdl[a] = v;
  endtask

  task automatic rd_reg(logic [6:0] a, output logic [15:0] v);
    frame_start();
    send_addr(1'b1, a);
    stb = 1'b0; din = 1'b1; hold();
    for (int i = 15; i >= 0; i--) begin
      stb = 1'b1; hold();
      stb = 1'b0; hold();
      v[i] = dout;
    end
    stb = 1'b1; hold();
    chk("R5 dout low after extra edge", {15'b0, dout}, 16'h0);
    din = 1'b0;
  endtask

  task automatic sweep_read(string tag);
    logic [15:0] v;
    for (int a = 0; a < 128; a++) begin
      rd_reg(7'(a), v);
      chk($sformatf("%s %s R2 R4 addr=%h", tag, cls(a), a), v, mdl[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int a = 0; a < 128; a++) mdl[a] = 16'h0;
    mdl[16] = PLAT;
    mdl[17] = FW;

    repeat (4) @(negedge clk);
    chk("R11 dout in reset", {15'b0, dout}, 16'h0);
    rst_n = 1'b1;
    hold();
    chk_ports("R10 reset value");

    sweep_read("R10");

    for (int a = 0; a < 128; a++) begin
      wr_reg(7'(a), 16'(a * 16'h9E37) ^ 16'h5AC3, 1'b0);
      chk_ports($sformatf("%s write addr=%h", cls(a), a));
    end
    sweep_read("post-write");

    // R3: register unchanged after 15 bits, updated after 16th
    wr_reg(7'h41, 16'hA5F0, 1'b1);
    chk_ports("R3 after 16th bit");

    // R1: abort mid-data
    frame_start();
    send_addr(1'b0, 7'h20);
    stb = 1'b0; hold();
    for (int i = 0; i < 8; i++) begin
      din = 1'b1; hold(); stb = 1'b1; hold(); stb = 1'b0; hold();
    end
    clr = 1'b0; hold(); clr = 1'b1; hold();
    chk_ports("R1 abort in data phase");

    // R1: abort mid-address, then a clean write must land on its own address
    frame_start();
    for (int i = 0; i < 4; i++) begin
      stb = 1'b0; din = 1'b1; hold(); stb = 1'b1; hold();
    end
    wr_reg(7'h21, 16'h3C3C, 1'b0);
    chk_ports("R1 fresh frame after address abort");

    // R1: abort mid-read, then read again
    frame_start();
    send_addr(1'b1, 7'h11);
    stb = 1'b0; hold();
    for (int i = 0; i < 5; i++) begin
      stb = 1'b1; hold(); stb = 1'b0; hold();
    end
    rd_reg(7'h11, v);
    chk("R1 R7 read after aborted read", v, FW);

    // R5: surplus strobe edges after a write
    wr_reg(7'h31, 16'h0FF0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      stb = 1'b0; din = i[0]; hold(); stb = 1'b1; hold();
    end
    chk("R5 dout stays low on surplus edges", {15'b0, dout}, 16'h0);
    chk_ports("R5 surplus edges");
    rd_reg(7'h31, v);
    chk("R5 R8 readback after surplus edges", v, 16'h0FF0);

    // R6 R7 R9: writes to read-only and unmapped addresses
    wr_reg(7'h10, 16'hFFFF, 1'b0);
    wr_reg(7'h11, 16'h0000, 1'b0);
    wr_reg(7'h22, 16'hBEEF, 1'b0);
    wr_reg(7'h7F, 16'h1234, 1'b0);
    chk_ports("R6 R7 R9 ignored writes");
    rd_reg(7'h10, v); chk("R6 platform id", v, PLAT);
    chk("R6 manufacturer byte", {8'h0, v[7:0]}, 16'h0001);
    rd_reg(7'h11, v); chk("R7 firmware id", v, FW);
    chk("R7 major field zero", {12'h0, v[11:8]}, 16'h0);
    rd_reg(7'h22, v); chk("R9 unmapped read", v, 16'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule